// File: doc/BRIEF.md
# Gated synchronous clock divider

This block turns one input clock into three slower clocks at one half, one quarter and one eighth of its rate. The three outputs are the bits of a single 3-bit up-counter. Every bit is clocked by the same internal clock, so wherever two outputs switch they do so on the same input edge.

The internal clock is the input clock gated by an active-low enable. The enable is captured on the falling input edge, which means the gate only opens or closes while the input clock is low. Every high phase that reaches the counter is therefore a full input high phase. No shortened pulse can upset the stages.

A master reset clears the counter and the enable capture. Several instances that leave reset on the same edge then divide in phase. The gated internal clock is also brought out so that its pulse shape can be observed.

Top module: `cdiv_gated_top`

## Requirements
- R1: While mr_i is high, div2_o, div4_o and div8_o are low and clk_gated_o is low. The effect takes hold asynchronously, without waiting for a clock edge. The enable capture is cleared, so a rising input edge that comes before the first falling edge after release does not count.
- R2: The word {div8_o, div4_o, div2_o} is a 3-bit up-counter. It advances by one, modulo 8, on each rising input edge at which the captured enable is active.
- R3: div4_o changes only on an edge at which div2_o falls from 1 to 0. div8_o changes only on an edge at which div4_o falls from 1 to 0.
- R4: en_n_i takes effect only at a falling input edge. A change made after a falling edge does not alter the count at the next rising edge; it first acts at the rising edge after the following falling edge.
- R5: Each high pulse of clk_gated_o begins while clk_i is high and lasts exactly one input high phase.
- R6: While the captured enable is inactive (en_n_i = 1), the three outputs hold their levels. On re-enable, counting resumes from the held value.
- R7: After release of mr_i with en_n_i held at 0, the first counted rising edge sets div2_o to 1, and the word reads 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock |
| mr_i | input | 1 | Master reset, asynchronous, active high |
| en_n_i | input | 1 | Enable, active low, captured on the falling edge of clk_i |
| div2_o | output | 1 | Input clock divided by 2 (counter bit 0) |
| div4_o | output | 1 | Input clock divided by 4 (counter bit 1) |
| div8_o | output | 1 | Input clock divided by 8 (counter bit 2) |
| clk_gated_o | output | 1 | Gated internal clock |

## Verification
The divider is first run with the enable held on for more than two full wraps of the counter. This shows that the three outputs count in binary order and that the carries line up. Runs of disabled cycles followed by re-enable tell a holding counter apart from one that slips or restarts. An alternating enable pattern separates counting at each enabled edge from counting at every edge. Enable changes placed just before and just after the falling edge show whether the enable is really captured on that edge, rather than taken level-sensitively or on the rising edge. Two resets, one with a nonzero count, show that reset clears both the counter and the enable capture. Every gated pulse is measured against the input high phase.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;
  localparam int unsigned CDIV_STAGES = 3;
  typedef logic [CDIV_STAGES-1:0] cdiv_cnt_t;
endpackage

// File: rtl/cdiv_en_capture.sv
module cdiv_en_capture (
  input  logic clk_i,
  input  logic mr_i,
  input  logic en_n_i,
  output logic en_q_o
);
  logic en_d;

  always_comb begin
    en_d = ~en_n_i;
  end

  always_ff @(negedge clk_i or posedge mr_i) begin
    if (mr_i) en_q_o <= 1'b0;
    else      en_q_o <= en_d;
  end
endmodule

// File: rtl/cdiv_clk_gate.sv
module cdiv_clk_gate (
  input  logic clk_i,
  input  logic en_i,
  output logic gclk_o
);
  assign gclk_o = clk_i & en_i;
endmodule

// File: rtl/cdiv_counter.sv
module cdiv_counter #(
  parameter int unsigned WIDTH = 3
) (
  input  logic             gclk_i,
  input  logic             mr_i,
  output logic [WIDTH-1:0] cnt_o
);
  localparam logic [WIDTH-1:0] ONE = {{(WIDTH-1){1'b0}}, 1'b1};
  logic [WIDTH-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_o + ONE;
  end

  always_ff @(posedge gclk_i or posedge mr_i) begin
    if (mr_i) cnt_o <= '0;
    else      cnt_o <= cnt_d;
  end
endmodule

// File: rtl/cdiv_gated_top.sv
module cdiv_gated_top
  import cdiv_pkg::*;
(
  input  logic clk_i,
  input  logic mr_i,
  input  logic en_n_i,
  output logic div2_o,
  output logic div4_o,
  output logic div8_o,
  output logic clk_gated_o
);
  localparam int unsigned W = CDIV_STAGES;

  logic      en_q;
  logic      gclk;
  cdiv_cnt_t cnt;

  cdiv_en_capture u_en (
    .clk_i  (clk_i),
    .mr_i   (mr_i),
    .en_n_i (en_n_i),
    .en_q_o (en_q)
  );

  cdiv_clk_gate u_gate (
    .clk_i  (clk_i),
    .en_i   (en_q),
    .gclk_o (gclk)
  );

  cdiv_counter #(.WIDTH(W)) u_cnt (
    .gclk_i (gclk),
    .mr_i   (mr_i),
    .cnt_o  (cnt)
  );

  assign div2_o      = cnt[0];
  assign div4_o      = cnt[1];
  assign div8_o      = cnt[2];
  assign clk_gated_o = gclk;

  // R1: reset holds counter and enable capture cleared
  p_reset_clear_r1: assert property (@(posedge clk_i)
    mr_i |-> (cnt == '0) && !en_q);

  // R2: enabled rising edge advances the count by one
  p_step_r2: assert property (@(posedge clk_i) disable iff (mr_i)
    en_q |=> (cnt == cdiv_cnt_t'($past(cnt) + 1'b1)));

  // R6: disabled rising edge leaves the count alone
  p_hold_r6: assert property (@(posedge clk_i) disable iff (mr_i)
    !en_q |=> (cnt == $past(cnt)));

  // R3: a higher stage moves only when the stage below falls
  for (genvar g = 1; g < W; g++) begin : g_align
    p_carry_align_r3: assert property (@(posedge clk_i) disable iff (mr_i)
      (cnt[g] != $past(cnt[g])) |-> ($past(cnt[g-1]) && !cnt[g-1]));
  end
endmodule

// File: tb/cdiv_gated_top_tb_top.sv
`timescale 1ns/1ps
module cdiv_gated_top_tb_top;
  logic clk_i = 1'b0;
  logic mr_i;
  logic en_n_i;
  logic div2_o, div4_o, div8_o, clk_gated_o;

  int n_chk = 0;
  int n_fail = 0;
  int        exp_q[$];
  string     tag_q[$];
  int        cnt_m;
  bit        en_m;
  realtime   t_gr;
  bit        gr_seen = 1'b0;
  bit        done = 1'b0;

  always #10 clk_i = ~clk_i;

  cdiv_gated_top dut_i (
    .clk_i(clk_i), .mr_i(mr_i), .en_n_i(en_n_i),
    .div2_o(div2_o), .div4_o(div4_o), .div8_o(div8_o),
    .clk_gated_o(clk_gated_o)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // driver: one input cycle; late=1 changes en_n_i after the falling edge
  task automatic cyc(input bit v, input bit late, input string tag);
    @(posedge clk_i);
    if (!late) begin
      #5 en_n_i = v;
      en_m = ~v;
      cnt_m = (cnt_m + int'(en_m)) % 8;
    end else begin
      #15 en_n_i = v;
      cnt_m = (cnt_m + int'(en_m)) % 8;
      en_m = ~v;
    end
    exp_q.push_back(cnt_m);
    tag_q.push_back(tag);
  endtask

  task automatic rst_assert();
    @(posedge clk_i);
    #12 mr_i = 1'b1;
    exp_q.delete();
    tag_q.delete();
    cnt_m = 0;
    en_m = 1'b0;
    #1;
    chk({div8_o, div4_o, div2_o} == 3'd0, "R1 outputs under reset",
        int'({div8_o, div4_o, div2_o}), 0);
    chk(clk_gated_o == 1'b0, "R1 gated clock under reset", int'(clk_gated_o), 0);
  endtask

  // release after the falling edge with enable requested: first edge not counted
  task automatic rst_release();
    @(posedge clk_i);
    #5 en_n_i = 1'b0;
    #10 mr_i = 1'b0;
    exp_q.push_back(cnt_m);
    tag_q.push_back("R1 enable capture cleared");
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(posedge clk_i);
      #2;
      if (exp_q.size() > 0) begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({div8_o, div4_o, div2_o} == e[2:0], t, int'({div8_o, div4_o, div2_o}), e);
      end
    end
  end

  // R5: gated pulse shape
  always @(posedge clk_gated_o) begin
    t_gr = $realtime;
    gr_seen = 1'b1;
    chk(clk_i === 1'b1, "R5 gated rise inside input high", int'(clk_i), 1);
  end

  always @(negedge clk_gated_o) begin
    if (gr_seen && !mr_i) begin
      realtime w;
      w = $realtime - t_gr;
      chk((w > 9.99) && (w < 10.01), "R5 gated high width ps", int'(w * 1000.0), 10000);
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", n_chk, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    mr_i = 1'b1;
    en_n_i = 1'b1;
    cnt_m = 0;
    en_m = 1'b0;
    repeat (3) @(posedge clk_i);
    #12;
    chk({div8_o, div4_o, div2_o} == 3'd0, "R1 reset state",
        int'({div8_o, div4_o, div2_o}), 0);
    chk(clk_gated_o == 1'b0, "R1 gated clock idle in reset", int'(clk_gated_o), 0);
    rst_release();
    cyc(1'b0, 1'b0, "R7 first counted edge");
    for (int i = 0; i < 19; i++) cyc(1'b0, 1'b0, "R2 free count");
    for (int i = 0; i < 5; i++) cyc(1'b1, 1'b0, "R6 hold while disabled");
    for (int i = 0; i < 4; i++) cyc(1'b0, 1'b0, "R6 resume after enable");
    cyc(1'b1, 1'b1, "R4 late disable still counts");
    cyc(1'b1, 1'b0, "R4 late disable takes effect");
    cyc(1'b1, 1'b0, "R6 hold");
    cyc(1'b0, 1'b1, "R4 late enable not yet counted");
    cyc(1'b0, 1'b0, "R4 late enable now counted");
    for (int i = 0; i < 9; i++) cyc(1'b0, 1'b0, "R3 carry alignment");
    for (int i = 0; i < 12; i++) cyc(bit'(i % 2), 1'b0, "R2 alternating enable");
    cyc(1'b0, 1'b0, "R2 count");
    cyc(1'b0, 1'b0, "R2 count");
    rst_assert();
    repeat (2) @(posedge clk_i);
    rst_release();
    cyc(1'b0, 1'b0, "R7 first edge after second reset");
    for (int i = 0; i < 9; i++) cyc(1'b0, 1'b0, "R2 count after reset");
    repeat (3) @(posedge clk_i);
    #5;
    chk(exp_q.size() == 0, "R2 scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule